// File: doc/BRIEF.md
# Serial-Loaded Switch Control Register

This block drives eight independent on/off switch-enable bits from a three-wire serial control interface. A controller presents one data bit at a time on `ser_in` and raises `ser_clk`. Each rising edge of `ser_clk` moves the register contents one place toward the far end and takes the new bit in at the near end. The bit pushed off the far end comes out on `ser_out`, so several blocks can be chained with one data line and shared clock and latch controls.

Between the register and the outputs sits a holding stage controlled by `latch_en`. While `latch_en` is low, the outputs track the register. When it rises, the outputs freeze, and the next pattern can be shifted in without disturbing the live switches. The asynchronous `clr` input opens every channel at once, whatever the other inputs are doing. The serial controls are treated as slow signals: they are sampled into the `clk` domain through a short synchronizer, and the serial clock's rising edge is detected there. The holding stage is a clocked register rather than a level latch.

Top module: `swctl_chain`

## Requirements
- R1: Each sampled low-to-high transition of `ser_clk` shifts the register by one place. The value of `ser_in` sampled with that transition enters bit 0, and every other bit n moves to bit n+1.
- R2: `ser_out` always equals register bit 7. A bit therefore appears on `ser_out` once seven more shifts have followed its own.
- R3: While `latch_en` is low, `sw_en` equals the register contents, and a new shift shows on `sw_en` in the same clock cycle as in the register.
- R4: While `latch_en` is high, `sw_en` holds the value it had when `latch_en` rose, however many shifts occur. Shifting still proceeds and is visible on `ser_out`.
- R5: If a `ser_clk` rise and a `latch_en` rise are sampled in the same cycle, `sw_en` keeps the value from before that shift. The register still takes the shift.
- R6: Asserting `clr` drives all of `sw_en` to 0 without waiting for a `clk` edge. `sw_en` stays 0 while `clr` is high, whatever `ser_clk` and `latch_en` do, and stays 0 after release until a new value passes the holding stage.
- R7: With `CLEAR_SHIFTER`=1 (the default), `clr` also empties the register asynchronously. `ser_out` reads 0, and after release with `latch_en` low `sw_en` stays 0.
- R8: `sw_en[n]`=1 closes channel n and 0 opens it. Register bit n drives channel n only, so any of the 256 patterns can be loaded.
- R9: A synchronous `rst` high at a `clk` edge clears the register, the holding stage and the synchronizer, giving `sw_en`=0 and `ser_out`=0.
- R10: Input changes pass `SYNC_STAGES` (default 2) sampling flops. A `ser_clk` rise first changes `ser_out` and `sw_en` at the (`SYNC_STAGES`+1)-th `clk` rising edge after it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling and state updates |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Asynchronous active-high clear; opens all channels |
| ser_clk | input | 1 | Serial shift clock, rising edge shifts |
| ser_in | input | 1 | Serial data input |
| latch_en | input | 1 | Low: outputs follow register; high: outputs hold |
| ser_out | output | 1 | Register bit 7, for chaining |
| sw_en | output | 8 | Switch enables, bit n for channel n, 1 = closed |

## Verification
Two events can collide in one sampled cycle: a serial shift and a rising `latch_en`. The same goes for a shift and an asserted `clr`. The bench provokes the first by driving `ser_clk` and `latch_en` high at the same falling `clk` edge, so the synchronizer delivers both together. It then expects `sw_en` to keep the pre-shift pattern while `ser_out` and the later released outputs show that the shift still happened. For the second, it pulses `ser_clk` while `clr` is held and expects all-zero outputs both during and after the clear.

// File: rtl/swctl_pkg.sv
package swctl_pkg;

  // One sample of the serial control inputs, carried together through the
  // synchronizer so that data, shift clock and hold stay aligned.
  typedef struct packed {
    logic sclk;
    logic sdat;
    logic hold;
  } ctl_sample_t;

endpackage

// File: rtl/swctl_sampler.sv
module swctl_sampler
  import swctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_clk,
  input  logic ser_in,
  input  logic latch_en,
  output logic shift,
  output logic sdat,
  output logic hold
);

  localparam int LAST = SYNC_STAGES - 1;

  ctl_sample_t pipe [SYNC_STAGES];
  logic        sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '0;
      sclk_prev <= 1'b0;
    end else begin
      pipe[0] <= '{sclk: ser_clk, sdat: ser_in, hold: latch_en};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
      sclk_prev <= pipe[LAST].sclk;
    end
  end

  assign shift = pipe[LAST].sclk & ~sclk_prev;
  assign sdat  = pipe[LAST].sdat;
  assign hold  = pipe[LAST].hold;

endmodule

// File: rtl/swctl_shifter.sv
module swctl_shifter #(
  parameter int WIDTH         = 8,
  parameter bit CLEAR_SHIFTER = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift,
  input  logic             sdat,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] nxt,
  output logic             ser_out
);

  assign nxt     = shift ? {q[WIDTH-2:0], sdat} : q;
  assign ser_out = q[WIDTH-1];

  generate
    if (CLEAR_SHIFTER) begin : g_async_clr
      always_ff @(posedge clk or posedge clr) begin
        if (clr)      q <= '0;
        else if (rst) q <= '0;
        else          q <= nxt;
      end
    end else begin : g_keep_on_clr
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
      end
    end
  endgenerate

  // R1: new bit lands in bit 0
  a_r1_entry: assert property (@(posedge clk) disable iff (rst || clr)
    shift |=> (q[0] == $past(sdat)));

  // R2: tail bit moves out on the serial output
  a_r2_tail: assert property (@(posedge clk) disable iff (rst || clr)
    shift |=> (ser_out == $past(q[WIDTH-2])));

  // R1: no sampled edge, no movement
  a_r1_idle: assert property (@(posedge clk) disable iff (rst || clr)
    !shift |=> $stable(q));

endmodule

// File: rtl/swctl_hold.sv
module swctl_hold #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             hold,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or posedge clr) begin
    if (clr)        q <= '0;
    else if (rst)   q <= '0;
    else if (!hold) q <= nxt;
  end

  // R6: clear keeps every channel open
  a_r6_clear_open: assert property (@(posedge clk) disable iff (rst)
    clr |-> (q == '0));

  // R4: frozen while hold is sampled high
  a_r4_frozen: assert property (@(posedge clk) disable iff (rst || clr)
    hold |=> $stable(q));

endmodule

// File: rtl/swctl_chain.sv
module swctl_chain #(
  parameter int CHANNELS      = 8,
  parameter int SYNC_STAGES   = 2,
  parameter bit CLEAR_SHIFTER = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                ser_clk,
  input  logic                ser_in,
  input  logic                latch_en,
  output logic                ser_out,
  output logic [CHANNELS-1:0] sw_en
);

  logic                shift_s;
  logic                sdat_s;
  logic                hold_s;
  logic [CHANNELS-1:0] shreg;
  logic [CHANNELS-1:0] shreg_nxt;

  swctl_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .ser_clk  (ser_clk),
    .ser_in   (ser_in),
    .latch_en (latch_en),
    .shift    (shift_s),
    .sdat     (sdat_s),
    .hold     (hold_s)
  );

  swctl_shifter #(.WIDTH(CHANNELS), .CLEAR_SHIFTER(CLEAR_SHIFTER)) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .shift   (shift_s),
    .sdat    (sdat_s),
    .q       (shreg),
    .nxt     (shreg_nxt),
    .ser_out (ser_out)
  );

  swctl_hold #(.WIDTH(CHANNELS)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .hold (hold_s),
    .nxt  (shreg_nxt),
    .q    (sw_en)
  );

  // R3: transparent stage tracks the register in the same cycle
  a_r3_follow: assert property (@(posedge clk) disable iff (rst || clr)
    !hold_s |=> (sw_en == shreg));

  // R9: synchronous reset empties outputs
  a_r9_reset: assert property (@(posedge clk)
    rst |=> (sw_en == '0 && ser_out == 1'b0));

endmodule

// File: tb/swctl_chain_tb_top.sv
`timescale 1ns/1ps
module swctl_chain_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clr = 1'b0;
  logic       ser_clk = 1'b0;
  logic       ser_in = 1'b0;
  logic       latch_en = 1'b0;
  logic       ser_out;
  logic [7:0] sw_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  swctl_chain dut_i (
    .clk(clk), .rst(rst), .clr(clr), .ser_clk(ser_clk),
    .ser_in(ser_in), .latch_en(latch_en), .ser_out(ser_out), .sw_en(sw_en)
  );

  localparam int NVEC = 6;
  localparam logic [7:0] VEC_DATA [NVEC] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h3C, 8'h00};
  localparam logic [7:0] VEC_SW   [NVEC] = '{8'hA5, 8'h01, 8'h80, 8'hFF, 8'h3C, 8'h00};
  localparam logic       VEC_SO   [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    ser_in = b;
    ser_clk = 1'b1;
    wait_n(4);
    ser_clk = 1'b0;
    wait_n(4);
  endtask

  // first bit sent ends in bit 7, last bit sent in bit 0
  task automatic load(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) shift_bit(v[i]);
  endtask

  initial begin
    wait_n(3);
    rst = 1'b0;
    wait_n(1);
    chk(sw_en, 8'h00, "R9 reset sw_en");
    chk({7'd0, ser_out}, 8'h00, "R9 reset ser_out");

    // R8 R1 R3: table of patterns, transparent stage
    for (int k = 0; k < NVEC; k++) begin
      load(VEC_DATA[k]);
      chk(sw_en, VEC_SW[k], "R8 R1 R3 pattern sw_en");
      chk({7'd0, ser_out}, {7'd0, VEC_SO[k]}, "R2 pattern ser_out");
    end

    // R2: single 1 walks to the tail after seven more shifts
    load(8'h01);
    for (int i = 0; i < 6; i++) shift_bit(1'b0);
    chk({7'd0, ser_out}, 8'h00, "R2 not yet at tail");
    shift_bit(1'b0);
    chk({7'd0, ser_out}, 8'h01, "R2 at tail");
    shift_bit(1'b0);
    chk({7'd0, ser_out}, 8'h00, "R2 shifted out");

    // R4: freeze, then shift a new pattern underneath
    load(8'h5A);
    latch_en = 1'b1;
    wait_n(4);
    load(8'hC3);
    chk(sw_en, 8'h5A, "R4 frozen sw_en");
    chk({7'd0, ser_out}, 8'h01, "R4 register moved");
    latch_en = 1'b0;
    wait_n(4);
    chk(sw_en, 8'hC3, "R3 release shows new pattern");

    // R5: shift and hold rise sampled together
    load(8'h5A);
    ser_in = 1'b1;
    ser_clk = 1'b1;
    latch_en = 1'b1;
    wait_n(4);
    chk(sw_en, 8'h5A, "R5 pre-shift value held");
    ser_clk = 1'b0;
    wait_n(4);
    chk({7'd0, ser_out}, 8'h01, "R5 shift taken");
    latch_en = 1'b0;
    wait_n(4);
    chk(sw_en, 8'hB5, "R5 released post-shift value");

    // R6 R7: asynchronous clear with a shift during it
    @(negedge clk);
    clr = 1'b1;
    #1;
    chk(sw_en, 8'h00, "R6 immediate open");
    chk({7'd0, ser_out}, 8'h00, "R7 register emptied");
    shift_bit(1'b1);
    chk(sw_en, 8'h00, "R6 shift ignored during clear");
    clr = 1'b0;
    wait_n(4);
    chk(sw_en, 8'h00, "R7 register stays empty after clear");

    // R6: clear while frozen
    load(8'h3C);
    latch_en = 1'b1;
    wait_n(4);
    clr = 1'b1;
    wait_n(2);
    clr = 1'b0;
    wait_n(4);
    chk(sw_en, 8'h00, "R6 frozen stage cleared");
    latch_en = 1'b0;
    wait_n(4);
    chk(sw_en, 8'h00, "R7 cleared register passes");

    // R10: latency of a shift edge
    ser_in = 1'b1;
    ser_clk = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(sw_en, 8'h00, "R10 not before stage count");
    @(posedge clk); @(negedge clk);
    chk(sw_en, 8'h01, "R10 visible at stage count plus one");
    ser_clk = 1'b0;
    wait_n(4);

    // R9: reset mid-operation
    load(8'hE7);
    rst = 1'b1;
    wait_n(2);
    rst = 1'b0;
    wait_n(4);
    chk(sw_en, 8'h00, "R9 reset clears outputs");
    chk({7'd0, ser_out}, 8'h00, "R9 reset clears register");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule